// File: doc/BRIEF.md
# Interleaved Dual-Bank SECDED Memory

This block is a 64-bit-wide on-chip RAM made of two 32-bit banks that work side by side. Each bank stores its own 32-bit word together with seven check bits of a single-error-correct, double-error-detect code. Bank 0 holds the lower half of every 64-bit word and bank 1 holds the upper half. A request carries a byte address and a width. A 64-bit access uses both banks. A 32-bit access uses the bank that address bit 2 selects.

Every read returns corrected data one cycle after the request is accepted. In that same cycle each bank produces its own error report: a corrected strobe, an uncorrectable strobe, the word index, the raw stored data and the syndrome. These reports feed two separate error monitors. Both halves of one 64-bit word share a word index, so a single access can produce two reports with the same index. System software turns the index into a byte address: bank 0 is at base + 8·index and bank 1 is at base + 4 + 8·index.

A write that covers only some bytes of a bank's word becomes a read-modify-write inside that bank. The block then stalls for one cycle. Corrections are never written back on their own. A stored word keeps its fault until it is written again.

Top module: `ildm_ram`

## Requirements
- R1: A 64-bit write stores `req_wdata[31:0]` in bank 0 and `req_wdata[63:32]` in bank 1. A 64-bit read raises `rd_vld` in the cycle after acceptance and returns both halves in the same lanes.
- R2: For a 32-bit access, address bit 2 selects the bank (0 = bank 0, 1 = bank 1). Data sits in that bank's natural lane (`[31:0]` or `[63:32]`). The other lane of `rd_data` reads as zero. The other bank is left unchanged, whatever its lane of `req_wdata` and `req_be` holds.
- R3: The word index is `req_addr[IDX_W+2:3]`, and address bits [1:0] are ignored. Bank 0's report carries the index in `err_idx[IDX_W-1:0]` and bank 1's report in `err_idx[2*IDX_W-1:IDX_W]`. A 64-bit read gives both reports the same index.
- R4: Each bank word is 39 bits: data in bits [31:0] and check bits in [38:32]. A read of a fault-free word raises no error strobe and reports a zero syndrome.
- R5: A read of a word with one flipped data bit returns the corrected data and raises `err_ce` for that bank only, in the `rd_vld` cycle. The report shows the raw stored data in that bank's lane of `err_raw` and a nonzero syndrome.
- R6: A correction is not written back. Reading the word again reports the same corrected error, and a full 32-bit rewrite of the word removes the error.
- R7: Two flipped bits in one bank raise `err_ue` for that bank only. The other bank of the same word independently reports nothing, or a corrected error with correct data.
- R8: A write whose byte enables cover 1 to 3 bytes of the selected bank does a read-modify-write. `req_rdy` is low for the cycle after acceptance. Unwritten bytes keep their corrected old values. An error found by the internal read raises that bank's strobe without `rd_vld`.
- R9: A write whose byte enables are all zero within the selected bank(s) changes no stored data.
- R10: After reset, `rd_vld`, `err_ce` and `err_ue` are low and `req_rdy` is high.
- R11: A single flipped check bit (bank bits 32 to 38) raises `err_ce` and leaves the returned data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request valid |
| req_rdy | output | 1 | Request can be accepted this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr | input | IDX_W+3 | Byte address |
| req_be | input | 8 | Byte enables over the 64-bit lane |
| req_wdata | input | 64 | Write data, natural lanes |
| rd_vld | output | 1 | Read data valid |
| rd_data | output | 64 | Corrected read data |
| err_ce | output | 2 | Per-bank corrected-error strobe |
| err_ue | output | 2 | Per-bank uncorrectable-error strobe |
| err_idx | output | 2*IDX_W | Per-bank word index of the report |
| err_raw | output | 64 | Per-bank raw stored data |
| err_syn | output | 14 | Per-bank syndrome {overall parity, Hamming position} |

## Verification
A corrupted stored word shows up one cycle after the next read of that index. It appears as a strobe on exactly one bank's error output, with corrected data on `rd_data` and the flipped bit visible in `err_raw`. A stale pipeline register or a wrong lane steer shows up as data or an index in the wrong half on that same cycle. A lost read-modify-write shows up on the following read of the word as missing merged bytes or a lingering error.

// File: rtl/ildm_pkg.sv
package ildm_pkg;

  localparam int DATA_W = 32;
  localparam int HAM_W  = 6;
  localparam int CW_W   = DATA_W + HAM_W + 1;

  // Hamming position (3..38, skipping powers of two) of data bit k
  function automatic logic [HAM_W-1:0] ham_pos(input int k);
    int n;
    logic [HAM_W-1:0] r;
    n = 0;
    r = '0;
    for (int p = 3; p <= DATA_W + HAM_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == k) r = HAM_W'(p);
        n++;
      end
    end
    return r;
  endfunction

  function automatic logic [HAM_W-1:0] ham_chk(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] c;
    logic [HAM_W-1:0] p;
    c = '0;
    for (int k = 0; k < DATA_W; k++) begin
      p = ham_pos(k);
      for (int i = 0; i < HAM_W; i++) begin
        if (p[i]) c[i] = c[i] ^ d[k];
      end
    end
    return c;
  endfunction

  // stored word: {overall parity, hamming checks, data}
  function automatic logic [CW_W-1:0] secded_enc(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] c;
    c = ham_chk(d);
    return {^{c, d}, c, d};
  endfunction

endpackage

// File: rtl/ildm_bank.sv
module ildm_bank #(
  parameter int IDX_W = 10,
  parameter int CW_W  = 39
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [CW_W-1:0]  wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [CW_W-1:0]  q
);
  localparam int DEPTH = 1 << IDX_W;

  logic [CW_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end

endmodule

// File: rtl/ildm_dec.sv
module ildm_dec
  import ildm_pkg::*;
(
  input  logic [CW_W-1:0]   cw,
  output logic [DATA_W-1:0] data,
  output logic              ce,
  output logic              ue,
  output logic [HAM_W:0]    syn
);
  logic [HAM_W-1:0]  s;
  logic              pe;
  logic [DATA_W-1:0] flip;

  always_comb begin
    s    = ham_chk(cw[DATA_W-1:0]) ^ cw[DATA_W+HAM_W-1:DATA_W];
    pe   = ^cw;
    flip = '0;
    for (int k = 0; k < DATA_W; k++) begin
      if (pe && ham_pos(k) == s) flip[k] = 1'b1;
    end
    data = cw[DATA_W-1:0] ^ flip;
    ce   = pe && (s <= HAM_W'(DATA_W + HAM_W));
    ue   = (!pe && s != '0) || (pe && s > HAM_W'(DATA_W + HAM_W));
    syn  = {pe, s};
  end

endmodule

// File: rtl/ildm_ram.sv
module ildm_ram
  import ildm_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_vld,
  output logic                 req_rdy,
  input  logic                 req_wr,
  input  logic                 req_wide,
  input  logic [IDX_W+2:0]     req_addr,
  input  logic [7:0]           req_be,
  input  logic [63:0]          req_wdata,
  output logic                 rd_vld,
  output logic [63:0]          rd_data,
  output logic [1:0]           err_ce,
  output logic [1:0]           err_ue,
  output logic [2*IDX_W-1:0]   err_idx,
  output logic [63:0]          err_raw,
  output logic [13:0]          err_syn
);
  localparam int NB    = 2;
  localparam int BYTES = DATA_W / 8;
  localparam int SYN_W = HAM_W + 1;

  logic             acc;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] s1_idx;
  logic [NB-1:0]    s1_rd;
  logic [NB-1:0]    s1_rmw;
  logic [NB-1:0]    part_v;
  logic             unused_lsb;

  assign acc        = req_vld && req_rdy;
  assign idx        = req_addr[IDX_W+2:3];
  assign unused_lsb = ^req_addr[1:0];
  assign req_rdy    = ~|s1_rmw;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld <= 1'b0;
    end else begin
      rd_vld <= acc && !req_wr;
    end
    if (acc) s1_idx <= idx;
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic               sel;
    logic [BYTES-1:0]   bm;
    logic               full;
    logic               re;
    logic               we;
    logic [IDX_W-1:0]   waddr;
    logic [CW_W-1:0]    wcw;
    logic [CW_W-1:0]    q;
    logic [DATA_W-1:0]  cor;
    logic               ce;
    logic               ue;
    logic [SYN_W-1:0]   syn;
    logic               rd_q;
    logic               rmw_q;
    logic [BYTES-1:0]   be_q;
    logic [DATA_W-1:0]  wd_q;
    logic [DATA_W-1:0]  merged;

    assign sel       = req_wide || (req_addr[2] == 1'(b));
    assign bm        = req_be[BYTES*b +: BYTES] & {BYTES{sel}};
    assign full      = (bm == {BYTES{1'b1}});
    assign part_v[b] = (bm != '0) && !full;
    assign re        = acc && sel && (!req_wr || part_v[b]);

    always_comb begin
      for (int j = 0; j < BYTES; j++) begin
        merged[8*j +: 8] = be_q[j] ? wd_q[8*j +: 8] : cor[8*j +: 8];
      end
    end

    assign we    = (acc && req_wr && full) || rmw_q;
    assign waddr = rmw_q ? s1_idx : idx;
    assign wcw   = rmw_q ? secded_enc(merged) : secded_enc(req_wdata[DATA_W*b +: DATA_W]);

    always_ff @(posedge clk) begin
      if (rst) begin
        rd_q  <= 1'b0;
        rmw_q <= 1'b0;
      end else begin
        rd_q  <= acc && !req_wr && sel;
        rmw_q <= acc && req_wr && part_v[b];
      end
      if (acc) begin
        be_q <= bm;
        wd_q <= req_wdata[DATA_W*b +: DATA_W];
      end
    end

    ildm_bank #(.IDX_W(IDX_W), .CW_W(CW_W)) u_bank (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wdata (wcw),
      .re    (re),
      .raddr (idx),
      .q     (q)
    );

    ildm_dec u_dec (
      .cw   (q),
      .data (cor),
      .ce   (ce),
      .ue   (ue),
      .syn  (syn)
    );

    assign s1_rd[b]                        = rd_q;
    assign s1_rmw[b]                       = rmw_q;
    assign rd_data[DATA_W*b +: DATA_W]     = rd_q ? cor : '0;
    assign err_ce[b]                       = (rd_q || rmw_q) && ce;
    assign err_ue[b]                       = (rd_q || rmw_q) && ue;
    assign err_idx[IDX_W*b +: IDX_W]       = s1_idx;
    assign err_raw[DATA_W*b +: DATA_W]     = q[DATA_W-1:0];
    assign err_syn[SYN_W*b +: SYN_W]       = syn;

    // R7: one bank never flags both kinds at once
    p_ce_ue_excl_r7: assert property (@(posedge clk) disable iff (rst)
      !(err_ce[b] && err_ue[b]));

    // R5: a corrected report differs from the raw word in at most one bit
    p_ce_onebit_r5: assert property (@(posedge clk) disable iff (rst)
      err_ce[b] |-> ($countones(q[DATA_W-1:0] ^ cor) <= 1));

    // R4: a clean read reports a zero syndrome
    p_clean_syn_r4: assert property (@(posedge clk) disable iff (rst)
      (rd_q && !err_ce[b] && !err_ue[b]) |-> (syn == '0));
  end

  // R1: read data appears only one cycle after an accepted read
  p_rdvld_src_r1: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> $past(req_vld && req_rdy && !req_wr));

  // R8: a partial write stalls the next cycle
  p_rmw_stall_r8: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_rdy && req_wr && (|part_v)) |=> !req_rdy);

  // R5: error strobes always trace back to an accepted request
  p_err_src_r5: assert property (@(posedge clk) disable iff (rst)
    ((|err_ce) || (|err_ue)) |-> $past(req_vld && req_rdy));

  // R2: a read lane with no selected bank stays zero
  p_lane_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_vld && !s1_rd[1]) |-> (rd_data[63:32] == '0));

endmodule

// File: tb/tb_ildm_ram.sv
module tb_ildm_ram;
  localparam int CLK_PER = 10;
  localparam int IDX_W   = 10;
  localparam int DEPTH   = 1 << IDX_W;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               req_vld = 1'b0;
  logic               req_rdy;
  logic               req_wr = 1'b0;
  logic               req_wide = 1'b0;
  logic [IDX_W+2:0]   req_addr = '0;
  logic [7:0]         req_be = '0;
  logic [63:0]        req_wdata = '0;
  logic               rd_vld;
  logic [63:0]        rd_data;
  logic [1:0]         err_ce;
  logic [1:0]         err_ue;
  logic [2*IDX_W-1:0] err_idx;
  logic [63:0]        err_raw;
  logic [13:0]        err_syn;

  always #(CLK_PER/2) clk = ~clk;

  ildm_ram #(.IDX_W(IDX_W)) dut (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_rdy(req_rdy), .req_wr(req_wr),
    .req_wide(req_wide), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rd_vld(rd_vld), .rd_data(rd_data), .err_ce(err_ce), .err_ue(err_ue),
    .err_idx(err_idx), .err_raw(err_raw), .err_syn(err_syn)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [31:0] mdl [2][DEPTH];

  logic        c_vld, c_rdy;
  logic [63:0] c_data, c_raw;
  logic [1:0]  c_ce, c_ue;
  logic [2*IDX_W-1:0] c_idx;
  logic [13:0] c_syn;

  function automatic logic [31:0] pat_lo(input int i);
    return 32'h1357_2468 ^ (32'(i) * 32'h9E37_79B1);
  endfunction
  function automatic logic [31:0] pat_hi(input int i);
    return ~(32'(i) * 32'h0101_1F3D) + 32'(i);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic req(input bit wr, input bit wide, input int idx, input bit bank,
                     input logic [1:0] lsb, input logic [7:0] be, input logic [63:0] wd);
    @(negedge clk);
    while (!req_rdy) @(negedge clk);
    req_vld   = 1'b1;
    req_wr    = wr;
    req_wide  = wide;
    req_addr  = {IDX_W'(idx), bank, lsb};
    req_be    = be;
    req_wdata = wd;
    @(negedge clk);
    req_vld = 1'b0;
    c_vld  = rd_vld;  c_rdy = req_rdy; c_data = rd_data; c_raw = err_raw;
    c_ce   = err_ce;  c_ue  = err_ue;  c_idx  = err_idx; c_syn = err_syn;
  endtask

  task automatic flip(input bit bank, input int idx, input int bitn);
    if (bank == 1'b0)
      dut.g_bank[0].u_bank.mem[idx][bitn] = ~dut.g_bank[0].u_bank.mem[idx][bitn];
    else
      dut.g_bank[1].u_bank.mem[idx][bitn] = ~dut.g_bank[1].u_bank.mem[idx][bitn];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    logic [31:0] v, nv, ev;
    logic [63:0] wd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk(!rd_vld && err_ce == 0 && err_ue == 0 && req_rdy, "R10 reset",
        {rd_vld, err_ce, err_ue, req_rdy}, 64'h1);

    // R1 R3 R4: full sweep of 64-bit writes then reads
    for (int i = 0; i < DEPTH; i++) begin
      req(1'b1, 1'b1, i, 1'b0, 2'b00, 8'hFF, {pat_hi(i), pat_lo(i)});
      mdl[0][i] = pat_lo(i);
      mdl[1][i] = pat_hi(i);
    end
    for (int i = 0; i < DEPTH; i++) begin
      req(1'b0, 1'b1, i, i[0], 2'(i), 8'h00, 64'd0);
      chk(c_vld && c_data == {mdl[1][i], mdl[0][i]}, "R1 wide read", c_data, {mdl[1][i], mdl[0][i]});
      chk(c_ce == 0 && c_ue == 0 && c_syn == 0, "R4 clean", {c_ce, c_ue, c_syn}, 64'd0);
      chk(c_idx == {IDX_W'(i), IDX_W'(i)}, "R3 index", 64'(c_idx), 64'({IDX_W'(i), IDX_W'(i)}));
    end

    // R2: 32-bit writes and reads steered by address bit 2
    for (int i = 0; i < 32; i++) begin
      v  = (32'(i) * 32'h0101_0101) ^ 32'hA5C3_0F96;
      wd = i[0] ? {v, 32'hDEAD_BEEF} : {32'hDEAD_BEEF, v};
      req(1'b1, 1'b0, i, i[0], 2'(i >> 1), 8'hFF, wd);
      mdl[i[0]][i] = v;
      req(1'b0, 1'b1, i, 1'b0, 2'b00, 8'h00, 64'd0);
      chk(c_data == {mdl[1][i], mdl[0][i]}, "R2 other bank kept", c_data, {mdl[1][i], mdl[0][i]});
      req(1'b0, 1'b0, i, i[0], 2'b11, 8'h00, 64'd0);
      chk(c_vld && c_data == (i[0] ? {v, 32'd0} : {32'd0, v}), "R2 narrow read", c_data,
          i[0] ? {v, 32'd0} : {32'd0, v});
    end

    // R9: zero byte enables in the selected bank(s)
    req(1'b1, 1'b0, 40, 1'b0, 2'b00, 8'hF0, 64'hFFFF_FFFF_FFFF_FFFF);
    req(1'b1, 1'b1, 40, 1'b0, 2'b00, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF);
    req(1'b0, 1'b1, 40, 1'b0, 2'b00, 8'h00, 64'd0);
    chk(c_data == {mdl[1][40], mdl[0][40]}, "R9 no effect", c_data, {mdl[1][40], mdl[0][40]});

    // R5 R6: every single data bit in each bank
    for (int b = 0; b < 2; b++) begin
      for (int k = 0; k < 32; k++) begin
        int ix;
        ix = 64 + 32 * b + k;
        flip(b[0], ix, k);
        req(1'b0, 1'b1, ix, 1'b0, 2'b00, 8'h00, 64'd0);
        chk(c_data == {mdl[1][ix], mdl[0][ix]}, "R5 corrected", c_data, {mdl[1][ix], mdl[0][ix]});
        chk(c_ce == (2'b01 << b) && c_ue == 0, "R5 strobe", {c_ce, c_ue}, {2'b01 << b, 2'b00});
        ev = mdl[b][ix] ^ (32'd1 << k);
        chk(c_raw[32*b +: 32] == ev && c_syn[7*b +: 7] != 0, "R5 raw/syn",
            c_raw[32*b +: 32], ev);
        req(1'b0, 1'b1, ix, 1'b0, 2'b00, 8'h00, 64'd0);
        chk(c_ce == (2'b01 << b), "R6 persists", c_ce, 2'b01 << b);
        req(1'b1, 1'b0, ix, b[0], 2'b00, 8'hFF, {mdl[b][ix], mdl[b][ix]});
        req(1'b0, 1'b1, ix, 1'b0, 2'b00, 8'h00, 64'd0);
        chk(c_ce == 0 && c_ue == 0 && c_data == {mdl[1][ix], mdl[0][ix]}, "R6 rewrite clears",
            {c_ce, c_ue}, 64'd0);
      end
    end

    // R11: single check-bit faults
    for (int k = 32; k < 39; k++) begin
      int ix;
      ix = 200 + k;
      flip(1'b1, ix, k);
      req(1'b0, 1'b1, ix, 1'b0, 2'b00, 8'h00, 64'd0);
      chk(c_ce == 2'b10 && c_ue == 0 && c_data == {mdl[1][ix], mdl[0][ix]} &&
          c_raw[63:32] == mdl[1][ix], "R11 check bit", c_data, {mdl[1][ix], mdl[0][ix]});
    end

    // R7: double fault in one bank, independent report in the other
    flip(1'b0, 300, 3);
    flip(1'b0, 300, 17);
    flip(1'b1, 300, 9);
    req(1'b0, 1'b1, 300, 1'b0, 2'b00, 8'h00, 64'd0);
    chk(c_ue == 2'b01 && c_ce == 2'b10, "R7 mixed", {c_ue, c_ce}, {2'b01, 2'b10});
    chk(c_data[63:32] == mdl[1][300], "R7 other half data", c_data[63:32], mdl[1][300]);
    chk(c_idx[IDX_W-1:0] == c_idx[2*IDX_W-1:IDX_W] && c_idx[IDX_W-1:0] == IDX_W'(300),
        "R7 shared index", 64'(c_idx), 64'({IDX_W'(300), IDX_W'(300)}));
    flip(1'b1, 301, 0);
    flip(1'b1, 301, 31);
    req(1'b0, 1'b1, 301, 1'b0, 2'b00, 8'h00, 64'd0);
    chk(c_ue == 2'b10 && c_ce == 2'b00 && c_data[31:0] == mdl[0][301], "R7 bank1 only",
        {c_ue, c_ce}, {2'b10, 2'b00});

    // R8: every partial byte-enable pattern, with a fault in the old word
    for (int p = 1; p < 15; p++) begin
      int ix;
      bit b;
      ix = 400 + p;
      b  = p[0];
      flip(b, ix, (p * 5) % 32);
      nv = 32'hC001_D00D ^ 32'(p);
      req(1'b1, 1'b0, ix, b, 2'b00, b ? {4'(p), 4'h0} : {4'h0, 4'(p)}, {nv, nv});
      chk(!c_rdy && !c_vld && c_ce == (b ? 2'b10 : 2'b01), "R8 rmw cycle",
          {c_rdy, c_vld, c_ce}, {1'b0, 1'b0, b ? 2'b10 : 2'b01});
      for (int j = 0; j < 4; j++) begin
        ev[8*j +: 8] = p[j] ? nv[8*j +: 8] : mdl[b][ix][8*j +: 8];
      end
      mdl[b][ix] = ev;
      req(1'b0, 1'b0, ix, b, 2'b00, 8'h00, 64'd0);
      chk(c_vld && c_ce == 0 && c_ue == 0 && c_data == (b ? {ev, 32'd0} : {32'd0, ev}),
          "R8 merged", c_data, b ? {ev, 32'd0} : {32'd0, ev});
    end

    finish_run();
  end

endmodule